// File: doc/BRIEF.md
# Double-Buffered Layer Configuration with Event Interrupt Collector

This unit keeps two copies of a display layer's configuration words. Software writes only the staging copies. The pixel pipeline sees only the live copies, such as the frame-buffer start address. A write to the reload-control address chooses when all staging words move into the live set. The move can happen on the next clock, or it can wait for the next vertical-blanking pulse. Waiting lets a new frame buffer or window take effect between frames and never partway through a frame.

The unit also gathers four one-cycle event pulses into a sticky status vector: pixel FIFO underrun, line reached, deferred reload finished, and memory transfer error. Each event has an enable bit and a write-one-to-clear bit. A single interrupt line is asserted while any enabled flag is set. Register writes use a plain strobe, address and data port. The bus adapter in front of the unit and the event sources behind it are separate blocks.

Top module: `layer_cfg_reload`

## Requirements
- R1: After reset, all live and staging words are zero. The status flags, the enable mask, the reload-busy output and the interrupt are all zero.
- R2: A write to a staging address (0 to NUM_REGS-1) changes no live word until a reload is performed.
- R3: Writing the control address (NUM_REGS) with bit 0 set is an immediate reload. All live words take the staging values on the clock edge after the write edge. The request then clears itself, and the reload-done flag is not set.
- R4: Writing the control address with bit 1 set (and bit 0 clear) is a deferred reload. Live words keep their values, and reload-busy stays high, until the first edge where vblank is high. On that edge every word is copied at once and reload-busy falls.
- R5: A deferred reload sets status bit 2 (reload done) on the edge where the copy happens. A vblank pulse with no deferred request pending copies nothing and sets no flag.
- R6: A pulse on ev_underrun sets status bit 0, a pulse on ev_line sets bit 1, and a pulse on ev_xfer_err sets bit 3. The flags stay set until cleared.
- R7: Writing the clear address (NUM_REGS+2) clears exactly the status bits written as 1. All other bits are left unchanged.
- R8: If a flag's event and its clear arrive in the same cycle, the flag stays set.
- R9: The enable mask is written at address NUM_REGS+1, bits 3:0, using the same bit positions as the status flags. irq is high exactly when some status bit and its enable bit are both 1. A set flag that is masked does not raise irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| vblank | input | 1 | Vertical-blanking pulse |
| ev_underrun | input | 1 | Pixel FIFO underrun event pulse |
| ev_line | input | 1 | Line-reached event pulse |
| ev_xfer_err | input | 1 | Memory transfer error event pulse |
| live_regs | output | NUM_REGS*DATA_W | Live configuration words, word i at bits i*DATA_W upward |
| reload_busy | output | 1 | A reload request is pending |
| status | output | 4 | Sticky event flags |
| irq_mask | output | 4 | Current enable mask |
| irq | output | 1 | Combined interrupt |

## Verification
The reload path is tried three ways:
- Staging writes with no request show that live words really are isolated.
- An immediate request shows the one-cycle copy and that it leaves the done flag alone.
- A deferred request, held across several idle cycles before vblank, separates waiting from copying early. A second vblank with nothing pending shows that a stray blanking pulse neither copies nor flags.

The flag path is tried three ways:
- Single events, followed by a partial clear, separate per-bit clearing from clearing the whole register.
- An event and its clear in the same cycle decide the priority between them.
- A mask that leaves the line flag disabled shows that a set but masked flag stays off the interrupt line, while an enabled one drives it.

// File: rtl/layer_cfg_pkg.sv
// Shared constants for the layer configuration reload unit.
// Assumes four event sources at fixed flag positions.
package layer_cfg_pkg;
    localparam int NUM_EVT      = 4;
    localparam int EVT_UNDERRUN = 0;
    localparam int EVT_LINE     = 1;
    localparam int EVT_RELOADED = 2;
    localparam int EVT_XFER_ERR = 3;
    localparam int CTRL_NOW_BIT = 0;
    localparam int CTRL_VB_BIT  = 1;
endpackage

// File: rtl/cfg_shadow_bank.sv
// Staging and live copies of NUM_REGS configuration words.
// Staging words are written one at a time. All live words copy together
// when load is high. Assumes at most one select bit is set per cycle.
module cfg_shadow_bank #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REGS-1:0]        sel,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       load,
    output logic [NUM_REGS*DATA_W-1:0] live_flat
);
    localparam int FLAT_W = NUM_REGS * DATA_W;

    logic [FLAT_W-1:0] stage_flat;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        // Staging word: takes software writes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_flat[g*DATA_W +: DATA_W] <= '0;
            else if (sel[g])
                stage_flat[g*DATA_W +: DATA_W] <= wdata;
        end

        // Live word: takes the staging value only on a load.
        always_ff @(posedge clk) begin
            if (!rst_n)
                live_flat[g*DATA_W +: DATA_W] <= '0;
            else if (load)
                live_flat[g*DATA_W +: DATA_W] <= stage_flat[g*DATA_W +: DATA_W];
        end
    end

    a_r2_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(live_flat));
    a_r3_copy_all: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> live_flat == $past(stage_flat));
endmodule

// File: rtl/cfg_reload_ctrl.sv
// Reload sequencer. An immediate request loads on the next edge.
// A deferred request waits for vblank and then reports completion.
// An immediate load also retires a deferred request that is pending.
module cfg_reload_ctrl
    import layer_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_code,
    input  logic       vblank,
    output logic       load,
    output logic       vb_done,
    output logic       busy
);
    logic now_req;
    logic vb_req;
    logic want_now;
    logic want_vb;

    assign want_now = ctrl_wr && ctrl_code[CTRL_NOW_BIT];
    assign want_vb  = ctrl_wr && !ctrl_code[CTRL_NOW_BIT] && ctrl_code[CTRL_VB_BIT];
    assign vb_done  = vb_req && vblank && !now_req;
    assign load     = now_req || vb_done;
    assign busy     = now_req || vb_req;

    // Immediate request: lives for exactly one cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) now_req <= 1'b0;
        else        now_req <= want_now;
    end

    // Deferred request: held until vblank or an immediate load retires it.
    always_ff @(posedge clk) begin
        if (!rst_n)                   vb_req <= 1'b0;
        else if (want_vb)             vb_req <= 1'b1;
        else if (now_req || vb_done)  vb_req <= 1'b0;
    end

    a_r3_now_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        now_req && !want_now |=> !now_req);
    a_r4_wait_vblank: assert property (@(posedge clk) disable iff (!rst_n)
        vb_req && !vblank && !now_req |=> vb_req);
    a_r5_done_retires: assert property (@(posedge clk) disable iff (!rst_n)
        vb_done && !want_vb |=> !busy);
endmodule

// File: rtl/cfg_event_flags.sv
// Sticky event flags with an enable mask, write-one-to-clear, and one
// combined interrupt. A set pulse wins over a clear in the same cycle.
module cfg_event_flags
    import layer_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] ev,
    input  logic               clr_wr,
    input  logic               en_wr,
    input  logic [NUM_EVT-1:0] wbits,
    output logic [NUM_EVT-1:0] flags,
    output logic [NUM_EVT-1:0] mask,
    output logic               irq
);
    logic [NUM_EVT-1:0] clr_bits;

    assign clr_bits = clr_wr ? wbits : '0;
    assign irq      = |(flags & mask);

    // Flag update: clear the selected bits, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_bits) | ev;
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask <= '0;
        else if (en_wr) mask <= wbits;
    end

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev != '0 |=> (flags & $past(ev)) == $past(ev));
    a_r7_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (flags & $past(wbits & ~ev)) == '0);
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> (flags & $past(flags)) == $past(flags));
    a_r9_no_flag_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        flags == '0 |-> !irq);
endmodule

// File: rtl/layer_cfg_reload.sv
// Top: decodes register writes into staging, control, enable and clear
// accesses. It joins the staging bank, the reload sequencer and the
// event flags. Address map: 0..NUM_REGS-1 staging, NUM_REGS control,
// NUM_REGS+1 enable mask, NUM_REGS+2 clear.
module layer_cfg_reload
    import layer_cfg_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       vblank,
    input  logic                       ev_underrun,
    input  logic                       ev_line,
    input  logic                       ev_xfer_err,
    output logic [NUM_REGS*DATA_W-1:0] live_regs,
    output logic                       reload_busy,
    output logic [3:0]                 status,
    output logic [3:0]                 irq_mask,
    output logic                       irq
);
    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] ADDR_IEN  = ADDR_W'(NUM_REGS + 1);
    localparam logic [ADDR_W-1:0] ADDR_ICLR = ADDR_W'(NUM_REGS + 2);

    logic [NUM_REGS-1:0] stage_sel;
    logic                load;
    logic                vb_done;
    logic [NUM_EVT-1:0]  ev_vec;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
        assign stage_sel[g] = wr_en && (wr_addr == ADDR_W'(g));
    end

    always_comb begin
        ev_vec               = '0;
        ev_vec[EVT_UNDERRUN] = ev_underrun;
        ev_vec[EVT_LINE]     = ev_line;
        ev_vec[EVT_RELOADED] = vb_done;
        ev_vec[EVT_XFER_ERR] = ev_xfer_err;
    end

    cfg_shadow_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (stage_sel),
        .wdata     (wr_data),
        .load      (load),
        .live_flat (live_regs)
    );

    cfg_reload_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (wr_en && wr_addr == ADDR_CTRL),
        .ctrl_code (wr_data[1:0]),
        .vblank    (vblank),
        .load      (load),
        .vb_done   (vb_done),
        .busy      (reload_busy)
    );

    cfg_event_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_vec),
        .clr_wr (wr_en && wr_addr == ADDR_ICLR),
        .en_wr  (wr_en && wr_addr == ADDR_IEN),
        .wbits  (wr_data[NUM_EVT-1:0]),
        .flags  (status),
        .mask   (irq_mask),
        .irq    (irq)
    );
endmodule

// File: tb/layer_cfg_reload_tb.sv
module layer_cfg_reload_tb;
    localparam int NR = 4;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam logic [AW-1:0] A_CTRL = 4'd4;
    localparam logic [AW-1:0] A_IEN  = 4'd5;
    localparam logic [AW-1:0] A_ICLR = 4'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic vblank = 1'b0, ev_underrun = 1'b0, ev_line = 1'b0, ev_xfer_err = 1'b0;
    logic [NR*DW-1:0] live_regs;
    logic reload_busy, irq;
    logic [3:0] status, irq_mask;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    layer_cfg_reload #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .vblank(vblank), .ev_underrun(ev_underrun),
        .ev_line(ev_line), .ev_xfer_err(ev_xfer_err), .live_regs(live_regs),
        .reload_busy(reload_busy), .status(status), .irq_mask(irq_mask),
        .irq(irq)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // One clock: inputs are driven at the negedge, sampled at the next negedge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic vb_pulse();
        vblank = 1'b1;
        tick();
        vblank = 1'b0;
    endtask

    task automatic stage_all(input logic [DW-1:0] base);
        for (int i = 0; i < NR; i++) wr(AW'(i), base + DW'(i));
    endtask

    function automatic logic [NR*DW-1:0] pattern(input logic [DW-1:0] base);
        logic [NR*DW-1:0] p;
        for (int i = 0; i < NR; i++) p[i*DW +: DW] = base + DW'(i);
        return p;
    endfunction

    task automatic t_reset();
        check("R1 live", live_regs, '0);
        check("R1 status", status, 4'h0);
        check("R1 mask", irq_mask, 4'h0);
        check("R1 irq", irq, 1'b0);
        check("R1 busy", reload_busy, 1'b0);
    endtask

    task automatic t_stage_hold();
        stage_all(32'hA0000000);
        tick(); tick();
        check("R2 live unchanged", live_regs, '0);
    endtask

    task automatic t_immediate();
        wr(A_CTRL, 32'h1);
        check("R3 not yet", live_regs, '0);
        check("R3 busy", reload_busy, 1'b1);
        tick();
        check("R3 copied", live_regs, pattern(32'hA0000000));
        check("R3 self-clear", reload_busy, 1'b0);
        check("R3 no done flag", status, 4'h0);
    endtask

    task automatic t_deferred();
        stage_all(32'hB0000010);
        wr(A_CTRL, 32'h2);
        for (int k = 0; k < 3; k++) tick();
        check("R4 waits", live_regs, pattern(32'hA0000000));
        check("R4 busy", reload_busy, 1'b1);
        vb_pulse();
        check("R4 copied at vblank", live_regs, pattern(32'hB0000010));
        check("R4 busy low", reload_busy, 1'b0);
        check("R5 done flag", status, 4'h4);
        wr(A_ICLR, 32'hF);
        stage_all(32'hC0000020);
        vb_pulse();
        check("R5 idle vblank no copy", live_regs, pattern(32'hB0000010));
        check("R5 idle vblank no flag", status, 4'h0);
    endtask

    task automatic t_events_clear();
        ev_underrun = 1'b1; tick(); ev_underrun = 1'b0;
        check("R6 underrun bit0", status, 4'h1);
        ev_line = 1'b1; tick(); ev_line = 1'b0;
        check("R6 line bit1", status, 4'h3);
        ev_xfer_err = 1'b1; tick(); ev_xfer_err = 1'b0;
        tick();
        check("R6 xfer bit3 sticky", status, 4'hB);
        wr(A_ICLR, 32'h1);
        check("R7 partial clear", status, 4'hA);
        wr(A_ICLR, 32'h8);
        check("R7 clear bit3", status, 4'h2);
    endtask

    task automatic t_set_wins();
        ev_underrun = 1'b1;
        wr(A_ICLR, 32'h3);
        ev_underrun = 1'b0;
        check("R8 set beats clear", status, 4'h1);
        wr(A_ICLR, 32'hF);
    endtask

    task automatic t_irq();
        wr(A_IEN, 32'hD);
        check("R9 mask readback", irq_mask, 4'hD);
        ev_line = 1'b1; tick(); ev_line = 1'b0;
        check("R9 masked line", irq, 1'b0);
        ev_xfer_err = 1'b1; tick(); ev_xfer_err = 1'b0;
        check("R9 enabled xfer", irq, 1'b1);
        wr(A_ICLR, 32'h8);
        check("R9 irq drops", irq, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stage_hold();
        t_immediate();
        t_deferred();
        t_events_clear();
        t_set_wins();
        t_irq();
        done = 1;
        summary();
    end
endmodule